// File: doc/BRIEF.md
# Multiprecision Integer Adder With Flags

This unit performs the add, subtract and negate arithmetic of a 32-bit processor datapath on byte, word or long operands. It also updates the five condition flags: extend, negative, zero, overflow and carry. The decoder supplies two operands, a size code, an operation code, a flag that marks an address-register destination, a 3-bit quick field and the flags currently held by the core. On a valid strobe the unit registers the new destination value and the new flag set.

The extend forms take the incoming extend bit as a carry or borrow. Their zero flag can only be cleared, never set. Software can therefore chain several narrow words into one wide number, preset zero before the first word, and read after the last word whether the whole number is zero.

For an address-register destination the operation always covers all 32 bits. A word source is sign-extended first, and the flags pass through unchanged. For a data destination narrower than 32 bits, the bits above the operand width keep their old value.

Top module: `mpadd_unit`

## Requirements
- R1: The size code selects the operand width: 00 byte (8 bits), 01 word (16 bits), 10 long (32 bits). Code 11 acts as long. Carry, overflow, negative and zero are all taken at the selected width only.
- R2: The flags are packed as {x, n, z, v, c}, bits 4 down to 0. Plain add (op 000) computes dst+src and plain subtract (op 001) computes dst−src. For both, n is the result sign bit, z is set when the result is zero, v is signed overflow and c is carry out (or borrow for subtract). x always equals c. Op 111 behaves as plain add.
- R3: Extend add (op 010) computes dst+src+x_in. Extend subtract (op 011) computes dst−src−x_in.
- R4: For the extend ops (010, 011, 101), z_out is 0 when the result is nonzero. Otherwise z_out equals z_in.
- R5: Negate (op 100) computes 0−dst. Extend negate (op 101) computes 0−dst−x_in. In both, c is the borrow.
- R6: Quick add (op 110) adds a value of 1 to 8 from `quick_i`, where 000 stands for 8 and other codes stand for themselves. `src_i` is ignored.
- R7: With `addr_dst_i`=1, `flags_o` takes `flags_i` unchanged, and all 32 result bits come from a full 32-bit operation whatever the size code.
- R8: With `addr_dst_i`=1 and a byte or word size, the source is src[15:0] sign-extended to 32 bits. The quick value is used as it stands.
- R9: With a data destination of byte or word size, result bits above the operand width equal the same bits of `dst_i`.
- R10: Add overflows when both addends have the same sign and the result sign differs. Subtract and negate overflow when the operand signs differ and the result sign differs from the minuend sign.
- R11: Result and flags are registered on the clock edge where `valid_i`=1, and `vld_o` is high for the following cycle. With `valid_i`=0 the outputs hold and `vld_o` is 0.
- R12: Synchronous active-high reset clears `result_o`, `flags_o` and `vld_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| addr_dst_i | input | 1 | Destination is an address register |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Destination operand |
| quick_i | input | 3 | Quick immediate field |
| flags_i | input | 5 | Current flags {x,n,z,v,c} |
| result_o | output | 32 | Registered destination value |
| flags_o | output | 5 | Registered flags {x,n,z,v,c} |
| vld_o | output | 1 | Result strobe, one cycle after valid_i |

## Verification
Several properties hold on every cycle and are checked continuously:
- x tracking c for data destinations.
- The zero flag never rising in an extend op.
- Flags passing through unchanged for address destinations.
- The upper bits of a byte operation being preserved.
- Outputs holding while no strobe is present.
- The reset state.
- A quick add never leaving an address register unchanged.

Arithmetic values depend on the operands and are shown only by the bench's directed scenarios, which compare results and flags against a signed reference model. These scenarios cover:
- Width-limited carries at each size.
- Overflow corners such as negating the most negative byte.
- Multiprecision chains with carry and extend bit set.
- The quick code 000 counting as 8.
- The sign extension of word sources into address registers.

// File: rtl/mpadd_pkg.sv
package mpadd_pkg;

    localparam int DW      = 32;
    localparam int NSZ     = 3;
    localparam int HALF_W  = DW / 2;
    localparam int QW      = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_SUB  = 3'b001,
        OP_ADDX = 3'b010,
        OP_SUBX = 3'b011,
        OP_NEG  = 3'b100,
        OP_NEGX = 3'b101,
        OP_ADDQ = 3'b110,
        OP_RSVD = 3'b111
    } op_e;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } ccr_t;

    // Operands as presented to the adder: b is not yet inverted.
    typedef struct packed {
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic          sub;
        logic          cin;
    } opnd_t;

    typedef struct packed {
        logic [DW-1:0] sum;
        logic          carry;
        logic          ovf;
        logic          neg;
        logic          zero;
    } arith_t;

    function automatic logic uses_extend(input op_e op);
        return (op == OP_ADDX) || (op == OP_SUBX) || (op == OP_NEGX);
    endfunction

    function automatic logic [1:0] lane_of(input size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    function automatic logic [DW-1:0] quick_value(input logic [QW-1:0] q);
        logic [DW-1:0] v;
        v = '0;
        if (q == '0) v[QW] = 1'b1;
        else         v[QW-1:0] = q;
        return v;
    endfunction

    function automatic logic [DW-1:0] sext_half(input logic [DW-1:0] v);
        return {{HALF_W{v[HALF_W-1]}}, v[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/mpadd_operand.sv
module mpadd_operand
    import mpadd_pkg::*;
(
    input  op_e             op_i,
    input  size_e           size_i,
    input  logic            addr_dst_i,
    input  logic [DW-1:0]   src_i,
    input  logic [DW-1:0]   dst_i,
    input  logic [QW-1:0]   quick_i,
    input  logic            x_i,
    output opnd_t           opnd_o
);

    logic [DW-1:0] src_eff;
    logic          x_used;
    logic          narrow;

    always_comb begin
        narrow = (size_i == SZ_BYTE) || (size_i == SZ_WORD);
        if (op_i == OP_ADDQ)
            src_eff = quick_value(quick_i);
        else if (addr_dst_i && narrow)
            src_eff = sext_half(src_i);
        else
            src_eff = src_i;

        x_used = uses_extend(op_i) ? x_i : 1'b0;

        case (op_i)
            OP_NEG, OP_NEGX: begin
                opnd_o.a   = '0;
                opnd_o.b   = dst_i;
                opnd_o.sub = 1'b1;
            end
            OP_SUB, OP_SUBX: begin
                opnd_o.a   = dst_i;
                opnd_o.b   = src_eff;
                opnd_o.sub = 1'b1;
            end
            default: begin
                opnd_o.a   = dst_i;
                opnd_o.b   = src_eff;
                opnd_o.sub = 1'b0;
            end
        endcase
        // a - b - x == a + ~b + (1 - x)
        opnd_o.cin = opnd_o.sub ? ~x_used : x_used;
    end

endmodule

// File: rtl/mpadd_core.sv
module mpadd_core
    import mpadd_pkg::*;
(
    input  opnd_t   opnd_i,
    input  size_e   size_i,
    input  logic    full_i,
    output arith_t  res_o
);

    logic [DW-1:0]  bb;
    logic [DW:0]    total;
    logic [NSZ-1:0] lane_cout;
    logic [NSZ-1:0] lane_ovf;
    logic [NSZ-1:0] lane_neg;
    logic [NSZ-1:0] lane_zero;
    logic [1:0]     sel;

    assign bb    = opnd_i.sub ? ~opnd_i.b : opnd_i.b;
    assign total = {1'b0, opnd_i.a} + {1'b0, bb} + {{DW{1'b0}}, opnd_i.cin};

    for (genvar g = 0; g < NSZ; g++) begin : g_lane
        localparam int W = 8 << g;
        if (W == DW) begin : g_top
            assign lane_cout[g] = total[DW];
        end else begin : g_mid
            // carry into bit W recovered from the sum bit
            assign lane_cout[g] = total[W] ^ opnd_i.a[W] ^ bb[W];
        end
        assign lane_neg[g]  = total[W-1];
        assign lane_zero[g] = (total[W-1:0] == '0);
        assign lane_ovf[g]  = (opnd_i.a[W-1] == bb[W-1]) && (total[W-1] != opnd_i.a[W-1]);
    end

    assign sel = full_i ? 2'd2 : lane_of(size_i);

    always_comb begin
        res_o.sum   = total[DW-1:0];
        res_o.carry = lane_cout[sel] ^ opnd_i.sub;
        res_o.ovf   = lane_ovf[sel];
        res_o.neg   = lane_neg[sel];
        res_o.zero  = lane_zero[sel];
    end

endmodule

// File: rtl/mpadd_flags.sv
module mpadd_flags
    import mpadd_pkg::*;
(
    input  arith_t  res_i,
    input  op_e     op_i,
    input  logic    addr_dst_i,
    input  ccr_t    cur_i,
    output ccr_t    nxt_o
);

    always_comb begin
        if (addr_dst_i) begin
            nxt_o = cur_i;
        end else begin
            nxt_o.c = res_i.carry;
            nxt_o.x = res_i.carry;
            nxt_o.n = res_i.neg;
            nxt_o.v = res_i.ovf;
            if (uses_extend(op_i))
                nxt_o.z = res_i.zero & cur_i.z;
            else
                nxt_o.z = res_i.zero;
        end
    end

endmodule

// File: rtl/mpadd_unit.sv
module mpadd_unit
    import mpadd_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            valid_i,
    input  logic [2:0]      op_i,
    input  logic [1:0]      size_i,
    input  logic            addr_dst_i,
    input  logic [DW-1:0]   src_i,
    input  logic [DW-1:0]   dst_i,
    input  logic [QW-1:0]   quick_i,
    input  logic [4:0]      flags_i,
    output logic [DW-1:0]   result_o,
    output logic [4:0]      flags_o,
    output logic            vld_o
);

    op_e           op;
    size_e         sz;
    ccr_t          cur;
    ccr_t          nxt;
    opnd_t         opnd;
    arith_t        ares;
    logic [DW-1:0] merged;

    assign op  = op_e'(op_i);
    assign sz  = size_e'(size_i);
    assign cur = ccr_t'(flags_i);

    mpadd_operand u_opnd (
        .op_i       (op),
        .size_i     (sz),
        .addr_dst_i (addr_dst_i),
        .src_i      (src_i),
        .dst_i      (dst_i),
        .quick_i    (quick_i),
        .x_i        (cur.x),
        .opnd_o     (opnd)
    );

    mpadd_core u_core (
        .opnd_i (opnd),
        .size_i (sz),
        .full_i (addr_dst_i),
        .res_o  (ares)
    );

    mpadd_flags u_flags (
        .res_i      (ares),
        .op_i       (op),
        .addr_dst_i (addr_dst_i),
        .cur_i      (cur),
        .nxt_o      (nxt)
    );

    always_comb begin
        if (addr_dst_i) begin
            merged = ares.sum;
        end else begin
            case (sz)
                SZ_BYTE: merged = {dst_i[DW-1:8], ares.sum[7:0]};
                SZ_WORD: merged = {dst_i[DW-1:HALF_W], ares.sum[HALF_W-1:0]};
                default: merged = ares.sum;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o <= '0;
            flags_o  <= '0;
            vld_o    <= 1'b0;
        end else begin
            vld_o <= valid_i;
            if (valid_i) begin
                result_o <= merged;
                flags_o  <= nxt;
            end
        end
    end

endmodule

// File: rtl/mpadd_unit_chk.sv
module mpadd_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        valid_i,
    input logic [2:0]  op_i,
    input logic [1:0]  size_i,
    input logic        addr_dst_i,
    input logic [31:0] dst_i,
    input logic [4:0]  flags_i,
    input logic [31:0] result_o,
    input logic [4:0]  flags_o,
    input logic        vld_o
);

    p_x_tracks_c_r2: assert property (@(posedge clk) disable iff (rst)
        valid_i && !addr_dst_i |=> flags_o[4] == flags_o[0]);

    p_sticky_z_r4: assert property (@(posedge clk) disable iff (rst)
        valid_i && !addr_dst_i && !flags_i[2] &&
        (op_i == 3'b010 || op_i == 3'b011 || op_i == 3'b101) |=> !flags_o[2]);

    p_quick_moves_r6: assert property (@(posedge clk) disable iff (rst)
        valid_i && addr_dst_i && op_i == 3'b110 |=> result_o != $past(dst_i));

    p_addr_flags_r7: assert property (@(posedge clk) disable iff (rst)
        valid_i && addr_dst_i |=> flags_o == $past(flags_i));

    p_keep_upper_r9: assert property (@(posedge clk) disable iff (rst)
        valid_i && !addr_dst_i && size_i == 2'b00 |=> result_o[31:8] == $past(dst_i[31:8]));

    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(result_o) && $stable(flags_o) && !vld_o);

    p_reset_clear_r12: assert property (@(posedge clk)
        rst |=> flags_o == 5'b0 && result_o == 32'b0 && !vld_o);

endmodule

bind mpadd_unit mpadd_unit_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .valid_i    (valid_i),
    .op_i       (op_i),
    .size_i     (size_i),
    .addr_dst_i (addr_dst_i),
    .dst_i      (dst_i),
    .flags_i    (flags_i),
    .result_o   (result_o),
    .flags_o    (flags_o),
    .vld_o      (vld_o)
);

// File: tb/sim_mpadd_unit.sv
module sim_mpadd_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic        addr_dst_i = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] dst_i = '0;
    logic [2:0]  quick_i = '0;
    logic [4:0]  flags_i = '0;
    logic [31:0] result_o;
    logic [4:0]  flags_o;
    logic        vld_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    mpadd_unit u0 (
        .clk(clk), .rst(rst), .valid_i(valid_i), .op_i(op_i), .size_i(size_i),
        .addr_dst_i(addr_dst_i), .src_i(src_i), .dst_i(dst_i), .quick_i(quick_i),
        .flags_i(flags_i), .result_o(result_o), .flags_o(flags_o), .vld_o(vld_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic longint sgn(input longint v, input int w);
        return v[w-1] ? v - (64'sd1 <<< w) : v;
    endfunction

    // Reference model from the requirements, in signed wide arithmetic.
    function automatic logic [36:0] model(input logic [2:0] op, input logic [1:0] sz, input logic ad,
                                          input logic [31:0] s, input logic [31:0] d,
                                          input logic [2:0] q, input logic [4:0] f);
        int w;
        longint m, sv, dv, r, sr, x, lim;
        logic [31:0] res;
        logic [4:0] nf;
        bit ext, sub, neg, zero;
        ext = (op == 3'b010) || (op == 3'b011) || (op == 3'b101);
        sub = (op == 3'b001) || (op == 3'b011);
        neg = (op == 3'b100) || (op == 3'b101);
        x = ext ? longint'(f[4]) : 0;
        if (op == 3'b110) sv = (q == 3'b000) ? 8 : longint'(q);
        else              sv = longint'(s);
        if (ad) begin
            if (op != 3'b110 && (sz == 2'b00 || sz == 2'b01))
                sv = sgn(longint'(s & 32'h0000_FFFF), 16);
            dv = longint'(d);
            r = neg ? -dv - x : (sub ? dv - sv - x : dv + sv + x);
            return {f, r[31:0]};
        end
        w = (sz == 2'b00) ? 8 : (sz == 2'b01) ? 16 : 32;
        m = (64'sd1 <<< w) - 1;
        sv = sv & m;
        dv = longint'(d) & m;
        if (neg)      begin r = -dv - x;      sr = -sgn(dv, w) - x; end
        else if (sub) begin r = dv - sv - x;  sr = sgn(dv, w) - sgn(sv, w) - x; end
        else          begin r = dv + sv + x;  sr = sgn(dv, w) + sgn(sv, w) + x; end
        lim = 64'sd1 <<< (w - 1);
        nf[0] = (r < 0) || (r > m);
        nf[4] = nf[0];
        nf[3] = r[w-1];
        nf[1] = (sr > lim - 1) || (sr < -lim);
        zero  = ((r & m) == 0);
        nf[2] = ext ? (zero && f[2]) : zero;
        res = (d & ~m[31:0]) | (r[31:0] & m[31:0]);
        return {nf, res};
    endfunction

    task automatic run(input string req, input logic [2:0] op, input logic [1:0] sz, input logic ad,
                       input logic [31:0] s, input logic [31:0] d, input logic [2:0] q,
                       input logic [4:0] f);
        logic [36:0] exp;
        @(negedge clk);
        op_i = op; size_i = sz; addr_dst_i = ad; src_i = s; dst_i = d; quick_i = q; flags_i = f;
        valid_i = 1'b1;
        @(negedge clk);
        valid_i = 1'b0;
        exp = model(op, sz, ad, s, d, q, f);
        chk(req, "result", result_o, exp[31:0]);
        chk(req, "flags", {27'b0, flags_o}, {27'b0, exp[36:32]});
        chk("R11", "strobe", {31'b0, vld_o}, 32'd1);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R12", "result", result_o, 32'h0);
        chk("R12", "flags", {27'b0, flags_o}, 32'h0);
        chk("R12", "strobe", {31'b0, vld_o}, 32'h0);
        rst = 1'b0;
    endtask

    task automatic t_widths();
        run("R1", 3'b000, 2'b00, 1'b0, 32'h0000_0001, 32'h1234_56FF, 3'd0, 5'b00000);
        chk("R1", "byte carry literal", {27'b0, flags_o}, {27'b0, 5'b10101});
        chk("R9", "byte merge literal", result_o, 32'h1234_5600);
        run("R10", 3'b000, 2'b01, 1'b0, 32'h0000_0001, 32'hAAAA_7FFF, 3'd0, 5'b00000);
        chk("R10", "word overflow literal", {27'b0, flags_o}, {27'b0, 5'b01010});
        run("R1", 3'b000, 2'b10, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 3'd0, 5'b00000);
        run("R1", 3'b000, 2'b11, 1'b0, 32'h8000_0000, 32'h8000_0000, 3'd0, 5'b00000);
        run("R2", 3'b111, 2'b10, 1'b0, 32'h1111_1111, 32'h2222_2222, 3'd0, 5'b11111);
    endtask

    task automatic t_sub();
        run("R2", 3'b001, 2'b10, 1'b0, 32'h0000_0001, 32'h0000_0000, 3'd0, 5'b00000);
        chk("R2", "long borrow literal", {27'b0, flags_o}, {27'b0, 5'b11001});
        run("R10", 3'b001, 2'b00, 1'b0, 32'h0000_0001, 32'h0000_0080, 3'd0, 5'b00000);
        chk("R10", "byte sub overflow literal", {27'b0, flags_o}, {27'b0, 5'b00010});
        run("R2", 3'b001, 2'b01, 1'b0, 32'h0000_1234, 32'h5555_1234, 3'd0, 5'b00000);
    endtask

    task automatic t_extend();
        run("R3", 3'b010, 2'b10, 1'b0, 32'h0000_0000, 32'hFFFF_FFFF, 3'd0, 5'b10100);
        chk("R4", "chain zero kept literal", {27'b0, flags_o}, {27'b0, 5'b10101});
        run("R4", 3'b010, 2'b00, 1'b0, 32'h0000_0000, 32'h0000_0000, 3'd0, 5'b00000);
        chk("R4", "zero not set literal", {31'b0, flags_o[2]}, 32'd0);
        run("R3", 3'b011, 2'b01, 1'b0, 32'h0000_0003, 32'h0000_0005, 3'd0, 5'b10100);
        chk("R3", "subx literal", result_o, 32'h0000_0001);
        run("R4", 3'b011, 2'b10, 1'b0, 32'h0000_0004, 32'h0000_0005, 3'd0, 5'b10100);
    endtask

    task automatic t_negate();
        run("R5", 3'b100, 2'b00, 1'b0, 32'hFFFF_FFFF, 32'h0000_0080, 3'd0, 5'b00000);
        chk("R5", "neg min byte literal", {27'b0, flags_o}, {27'b0, 5'b11011});
        run("R5", 3'b100, 2'b10, 1'b0, 32'h0, 32'h0000_0000, 3'd0, 5'b10000);
        run("R5", 3'b101, 2'b10, 1'b0, 32'h0, 32'h0000_0000, 3'd0, 5'b10100);
        chk("R5", "negx literal", result_o, 32'hFFFF_FFFF);
        run("R5", 3'b101, 2'b01, 1'b0, 32'h0, 32'h0000_0000, 3'd0, 5'b00100);
    endtask

    task automatic t_quick();
        run("R6", 3'b110, 2'b10, 1'b0, 32'hDEAD_BEEF, 32'h0000_000A, 3'b000, 5'b00000);
        chk("R6", "quick eight literal", result_o, 32'h0000_0012);
        run("R6", 3'b110, 2'b01, 1'b0, 32'h1234_5678, 32'h0000_FFFE, 3'b011, 5'b00000);
        chk("R6", "quick word wrap literal", result_o, 32'h0000_0001);
    endtask

    task automatic t_address();
        run("R8", 3'b000, 2'b01, 1'b1, 32'h1234_8000, 32'h0001_0000, 3'd0, 5'b01010);
        chk("R8", "sext literal", result_o, 32'h0000_8000);
        chk("R7", "flags pass literal", {27'b0, flags_o}, {27'b0, 5'b01010});
        run("R7", 3'b110, 2'b00, 1'b1, 32'h0, 32'h0000_FFFF, 3'b001, 5'b10101);
        chk("R7", "full width literal", result_o, 32'h0001_0000);
        run("R8", 3'b001, 2'b01, 1'b1, 32'h0000_FFFF, 32'h0000_0000, 3'd0, 5'b00000);
        run("R7", 3'b000, 2'b10, 1'b1, 32'h8000_0000, 32'h8000_0000, 3'd0, 5'b11111);
    endtask

    task automatic t_preserve();
        run("R9", 3'b000, 2'b01, 1'b0, 32'hFFFF_0001, 32'hDEAD_0001, 3'd0, 5'b00000);
        chk("R9", "word merge literal", result_o, 32'hDEAD_0002);
    endtask

    task automatic t_hold();
        logic [31:0] r0;
        logic [4:0]  f0;
        r0 = result_o; f0 = flags_o;
        @(negedge clk);
        op_i = 3'b001; size_i = 2'b10; src_i = 32'h5; dst_i = 32'h9; flags_i = 5'b11111;
        valid_i = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R11", "result held", result_o, r0);
        chk("R11", "flags held", {27'b0, flags_o}, {27'b0, f0});
        chk("R11", "no strobe", {31'b0, vld_o}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_widths();
        t_sub();
        t_extend();
        t_negate();
        t_quick();
        t_address();
        t_preserve();
        t_hold();
        t_reset();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule